// File: doc/BRIEF.md
# Memory-space router with shared code/xdata bus arbitration

This block connects a small 8-bit CPU core and a DMA master to three physical stores: flash program memory, an SRAM and a bank of memory-mapped registers. Each CPU request carries a space tag (code, internal data, register, external data), an address, a direct/indirect flag, a bit/byte flag with a bit index, and write data. The block decodes the request, drives one physical memory port, and returns read data with a valid strobe on the next cycle.

The external data space holds mirror windows onto the SRAM and the register bank, so the DMA master, which only issues external-data accesses, can reach all storage. Flash is read through one bus that serves code reads, external-data accesses and instruction prefetch. Prefetch gets the bus only when no data access claims it. A control register inside the block turns prefetch on and selects an alternate code mapping. Both are off after reset.

Top module: `mem_space_router`

## Requirements
- R1: A CPU write tagged code space (space code 0) is rejected: no memory is written, and `err_o` is high on the cycle after the request.
- R2: Internal data space (space code 1) addresses 0x00–0x7F reach SRAM under both direct and indirect addressing. Addresses 0x80–0xFF reach SRAM when the indirect flag is set.
- R3: A direct access in internal data space to 0x80–0xFF reaches the register bank, not SRAM. Register space (code 2) accepts only direct accesses to 0x80–0xFF.
- R4: Bit accesses (bit flag set, index 0–7) are accepted only for register addresses whose low three address bits are zero. A bit write changes only the indexed bit. A bit read returns that bit in data bit 0 with all other bits zero. A bit access anywhere else is an unmapped access.
- R5: In external data space (code 3), 0xFF00–0xFFFF mirrors SRAM bytes 0x00–0xFF, and 0x7080–0x70FF mirrors register addresses 0x80–0xFF.
- R6: External data addresses below 0x7080 read flash at the same address. Writes there are rejected as unmapped.
- R7: When the CPU and the DMA request in the same cycle, the CPU is served. `dma_ready_o` stays low while `cpu_req_i` is high, and the DMA request is served in the first cycle without a CPU request.
- R8: An instruction prefetch is not granted in a cycle where a CPU code or external-data access, or a DMA access, is granted. It may be granted alongside a CPU internal-data or register access.
- R9: The control register sits at register address 0xC8. Bit 0 enables prefetch and bit 1 selects the alternate code mapping. It resets to 0, so after reset `pf_grant_o` stays low. Its value reads back through the normal read path.
- R10: With the alternate mapping selected, CPU code reads of 0xFF00–0xFFFF return SRAM bytes 0x00–0xFF. Otherwise they return flash.
- R11: An access that hits no mapped region reads as 0x00, changes no storage, and raises `err_o` for exactly the cycle after that request.
- R12: Every granted read, including a prefetch, returns its data with a one-cycle valid strobe on the clock after the grant. Read data outputs are 0x00 while their valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request |
| cpu_space_i | input | 2 | 0 code, 1 internal data, 2 register, 3 external data |
| cpu_addr_i | input | 16 | CPU address |
| cpu_indirect_i | input | 1 | Indirect addressing flag |
| cpu_bit_i | input | 1 | Bit access flag |
| cpu_bitsel_i | input | 3 | Bit index for bit accesses |
| cpu_we_i | input | 1 | Write enable |
| cpu_wdata_i | input | 8 | Write data (bit 0 for bit writes) |
| cpu_rvalid_o | output | 1 | CPU read data valid |
| cpu_rdata_o | output | 8 | CPU read data |
| dma_req_i | input | 1 | DMA external-data request |
| dma_addr_i | input | 16 | DMA external-data address |
| dma_we_i | input | 1 | DMA write enable |
| dma_wdata_i | input | 8 | DMA write data |
| dma_ready_o | output | 1 | DMA request granted this cycle |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_rdata_o | output | 8 | DMA read data |
| pf_req_i | input | 1 | Instruction prefetch request |
| pf_addr_i | input | 16 | Prefetch flash address |
| pf_grant_o | output | 1 | Prefetch granted this cycle |
| pf_rvalid_o | output | 1 | Prefetch data valid |
| pf_rdata_o | output | 8 | Prefetch data |
| err_o | output | 1 | Unmapped or rejected access flag |
| flash_en_o | output | 1 | Flash read enable |
| flash_addr_o | output | 16 | Flash address |
| flash_rdata_i | input | 8 | Flash read data, one cycle after enable |
| sram_en_o | output | 1 | SRAM enable |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | 8 | SRAM address |
| sram_wdata_o | output | 8 | SRAM write data |
| sram_rdata_i | input | 8 | SRAM read data, one cycle after enable |
| sfr_en_o | output | 1 | Register bank enable |
| sfr_we_o | output | 1 | Register bank write enable |
| sfr_addr_o | output | 8 | Register address (0x80–0xFF) |
| sfr_wmask_o | output | 8 | Per-bit write mask |
| sfr_wdata_o | output | 8 | Register write data |
| sfr_rdata_i | input | 8 | Register read data, one cycle after enable |

## Verification
The assertions assume that the three memories return read data exactly one clock after their enable. They also assume that request inputs are held steady from one falling edge to the next, and that a bit index is only meaningful while the bit flag is set. The stimulus drives every request on the falling edge for a single cycle. It models each memory as a synchronous one-cycle store with a per-bit write mask on the register bank. It issues DMA accesses only in external data space, with no bit or indirect qualifiers.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic [1:0] {
    SP_CODE  = 2'd0,
    SP_DATA  = 2'd1,
    SP_SFR   = 2'd2,
    SP_XDATA = 2'd3
  } msr_space_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_FLASH,
    TGT_SRAM,
    TGT_SFR,
    TGT_CTRL
  } msr_tgt_e;
endpackage

// File: rtl/msr_decode.sv
module msr_decode
  import msr_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter logic [15:0] SRAM_BASE = 16'hFF00,
  parameter logic [15:0] SFR_BASE  = 16'h7080,
  parameter logic [7:0]  CTRL_ADDR = 8'hC8
) (
  input  logic [1:0]    space_i,
  input  logic [AW-1:0] addr_i,
  input  logic          indirect_i,
  input  logic          bit_i,
  input  logic          we_i,
  input  logic          alt_map_i,
  output msr_tgt_e      tgt_o,
  output logic [AW-1:0] paddr_o
);
  localparam logic [AW-1:0] BYTE_TOP = AW'(256);
  localparam logic [AW-1:0] SRAM_B   = AW'(SRAM_BASE);
  localparam logic [AW-1:0] SFR_B    = AW'(SFR_BASE);
  localparam logic [AW-1:0] SFR_END  = AW'(SFR_BASE) + AW'(128);

  msr_tgt_e      tgt;
  logic [AW-1:0] pa;

  always_comb begin
    tgt = TGT_NONE;
    pa  = addr_i;
    unique case (msr_space_e'(space_i))
      SP_CODE: begin
        if (!we_i) begin
          if (alt_map_i && addr_i >= SRAM_B) begin
            tgt = TGT_SRAM;
            pa  = addr_i - SRAM_B;
          end else begin
            tgt = TGT_FLASH;
          end
        end
      end
      SP_DATA: begin
        if (addr_i < BYTE_TOP) tgt = (!addr_i[7] || indirect_i) ? TGT_SRAM : TGT_SFR;
      end
      SP_SFR: begin
        if (!indirect_i && addr_i < BYTE_TOP && addr_i[7]) tgt = TGT_SFR;
      end
      SP_XDATA: begin
        if (addr_i >= SRAM_B) begin
          tgt = TGT_SRAM;
          pa  = addr_i - SRAM_B;
        end else if (addr_i >= SFR_B && addr_i < SFR_END) begin
          tgt = TGT_SFR;
          pa  = (addr_i - SFR_B) | AW'(8'h80);
        end else if (addr_i < SFR_B && !we_i) begin
          tgt = TGT_FLASH;
        end
      end
      default: tgt = TGT_NONE;
    endcase
    if (tgt == TGT_SFR && pa[7:0] == CTRL_ADDR) tgt = TGT_CTRL;
    // bit access only on 8-aligned register addresses
    if (bit_i && !((tgt == TGT_SFR || tgt == TGT_CTRL) && pa[2:0] == 3'd0)) tgt = TGT_NONE;
  end

  assign tgt_o   = tgt;
  assign paddr_o = pa;
endmodule

// File: rtl/msr_arbiter.sv
module msr_arbiter (
  input  logic cpu_req_i,
  input  logic cpu_bus_i,
  input  logic dma_req_i,
  input  logic pf_req_i,
  input  logic pf_en_i,
  output logic cpu_gnt_o,
  output logic dma_gnt_o,
  output logic pf_gnt_o
);
  logic bus_taken;

  assign cpu_gnt_o = cpu_req_i;
  assign dma_gnt_o = dma_req_i && !cpu_req_i;
  assign bus_taken = (cpu_req_i && cpu_bus_i) || dma_gnt_o;
  assign pf_gnt_o  = pf_req_i && pf_en_i && !bus_taken;
endmodule

// File: rtl/mem_space_router.sv
module mem_space_router
  import msr_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter logic [15:0] SRAM_BASE = 16'hFF00,
  parameter logic [15:0] SFR_BASE  = 16'h7080,
  parameter logic [7:0]  CTRL_ADDR = 8'hC8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic [1:0]    cpu_space_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_indirect_i,
  input  logic          cpu_bit_i,
  input  logic [2:0]    cpu_bitsel_i,
  input  logic          cpu_we_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_rvalid_o,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          dma_req_i,
  input  logic [AW-1:0] dma_addr_i,
  input  logic          dma_we_i,
  input  logic [DW-1:0] dma_wdata_i,
  output logic          dma_ready_o,
  output logic          dma_rvalid_o,
  output logic [DW-1:0] dma_rdata_o,
  input  logic          pf_req_i,
  input  logic [AW-1:0] pf_addr_i,
  output logic          pf_grant_o,
  output logic          pf_rvalid_o,
  output logic [DW-1:0] pf_rdata_o,
  output logic          err_o,
  output logic          flash_en_o,
  output logic [AW-1:0] flash_addr_o,
  input  logic [DW-1:0] flash_rdata_i,
  output logic          sram_en_o,
  output logic          sram_we_o,
  output logic [7:0]    sram_addr_o,
  output logic [DW-1:0] sram_wdata_o,
  input  logic [DW-1:0] sram_rdata_i,
  output logic          sfr_en_o,
  output logic          sfr_we_o,
  output logic [7:0]    sfr_addr_o,
  output logic [DW-1:0] sfr_wmask_o,
  output logic [DW-1:0] sfr_wdata_o,
  input  logic [DW-1:0] sfr_rdata_i
);
  localparam int unsigned BSW = $clog2(DW);

  msr_tgt_e      cpu_tgt, dma_tgt, a_tgt, r_tgt;
  logic [AW-1:0] cpu_pa, dma_pa, a_pa;
  logic          cpu_gnt, dma_gnt, pf_gnt, acc, a_we, a_bit;
  logic [DW-1:0] a_wd, rbyte, rdat;
  logic [2:0]    a_bs, r_bs;
  logic          r_cpu_rd, r_dma_rd, r_pf, r_bit, err_q;
  logic [1:0]    ctrl_q;
  logic          cpu_bus;

  msr_decode #(.AW(AW), .SRAM_BASE(SRAM_BASE), .SFR_BASE(SFR_BASE), .CTRL_ADDR(CTRL_ADDR)) u_dec_cpu (
    .space_i(cpu_space_i), .addr_i(cpu_addr_i), .indirect_i(cpu_indirect_i),
    .bit_i(cpu_bit_i), .we_i(cpu_we_i), .alt_map_i(ctrl_q[1]),
    .tgt_o(cpu_tgt), .paddr_o(cpu_pa)
  );

  msr_decode #(.AW(AW), .SRAM_BASE(SRAM_BASE), .SFR_BASE(SFR_BASE), .CTRL_ADDR(CTRL_ADDR)) u_dec_dma (
    .space_i(SP_XDATA), .addr_i(dma_addr_i), .indirect_i(1'b0),
    .bit_i(1'b0), .we_i(dma_we_i), .alt_map_i(ctrl_q[1]),
    .tgt_o(dma_tgt), .paddr_o(dma_pa)
  );

  assign cpu_bus = (cpu_space_i == SP_CODE) || (cpu_space_i == SP_XDATA);

  msr_arbiter u_arb (
    .cpu_req_i(cpu_req_i), .cpu_bus_i(cpu_bus), .dma_req_i(dma_req_i),
    .pf_req_i(pf_req_i), .pf_en_i(ctrl_q[0]),
    .cpu_gnt_o(cpu_gnt), .dma_gnt_o(dma_gnt), .pf_gnt_o(pf_gnt)
  );

  assign acc   = cpu_gnt || dma_gnt;
  assign a_tgt = cpu_gnt ? cpu_tgt : dma_tgt;
  assign a_pa  = cpu_gnt ? cpu_pa : dma_pa;
  assign a_we  = cpu_gnt ? cpu_we_i : dma_we_i;
  assign a_wd  = cpu_gnt ? cpu_wdata_i : dma_wdata_i;
  assign a_bit = cpu_gnt && cpu_bit_i;
  assign a_bs  = cpu_bitsel_i;

  assign dma_ready_o  = dma_gnt;
  assign pf_grant_o   = pf_gnt;

  assign flash_en_o   = (acc && a_tgt == TGT_FLASH) || pf_gnt;
  assign flash_addr_o = (acc && a_tgt == TGT_FLASH) ? a_pa : pf_addr_i;

  assign sram_en_o    = acc && a_tgt == TGT_SRAM;
  assign sram_we_o    = a_we;
  assign sram_addr_o  = a_pa[7:0];
  assign sram_wdata_o = a_wd;

  assign sfr_en_o     = acc && a_tgt == TGT_SFR;
  assign sfr_we_o     = a_we;
  assign sfr_addr_o   = a_pa[7:0];
  assign sfr_wmask_o  = a_bit ? (DW'(1) << a_bs[BSW-1:0]) : {DW{1'b1}};
  assign sfr_wdata_o  = a_bit ? {DW{a_wd[0]}} : a_wd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 2'b00;
    end else if (acc && a_we && a_tgt == TGT_CTRL) begin
      if (a_bit) begin
        if (a_bs < 3'd2) ctrl_q[a_bs[0]] <= a_wd[0];
      end else begin
        ctrl_q <= a_wd[1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_cpu_rd <= 1'b0;
      r_dma_rd <= 1'b0;
      r_pf     <= 1'b0;
      r_tgt    <= TGT_NONE;
      r_bit    <= 1'b0;
      r_bs     <= 3'd0;
      err_q    <= 1'b0;
    end else begin
      r_cpu_rd <= cpu_gnt && !cpu_we_i;
      r_dma_rd <= dma_gnt && !dma_we_i;
      r_pf     <= pf_gnt;
      r_tgt    <= acc ? a_tgt : TGT_NONE;
      r_bit    <= a_bit;
      r_bs     <= a_bs;
      err_q    <= acc && a_tgt == TGT_NONE;
    end
  end

  always_comb begin
    unique case (r_tgt)
      TGT_FLASH: rbyte = flash_rdata_i;
      TGT_SRAM:  rbyte = sram_rdata_i;
      TGT_SFR:   rbyte = sfr_rdata_i;
      TGT_CTRL:  rbyte = DW'(ctrl_q);
      default:   rbyte = '0;
    endcase
    rdat = r_bit ? DW'(rbyte[r_bs[BSW-1:0]]) : rbyte;
  end

  assign cpu_rvalid_o = r_cpu_rd;
  assign cpu_rdata_o  = r_cpu_rd ? rdat : '0;
  assign dma_rvalid_o = r_dma_rd;
  assign dma_rdata_o  = r_dma_rd ? rdat : '0;
  assign pf_rvalid_o  = r_pf;
  assign pf_rdata_o   = r_pf ? flash_rdata_i : '0;
  assign err_o        = err_q;

  p_code_ro_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_space_i == SP_CODE && cpu_we_i |=> err_o);

  p_bit_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_en_o && sfr_we_o |-> ($countones(sfr_wmask_o) == 1 || sfr_wmask_o == {DW{1'b1}}));

  p_cpu_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i |-> !dma_ready_o);

  p_pf_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_space_i == SP_XDATA) || dma_ready_o |-> !pf_grant_o);

  p_pf_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[0] |-> !pf_grant_o);

  p_err_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cpu_rdata_o == '0 && dma_rdata_o == '0);

  p_rd_lat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_we_i |=> cpu_rvalid_o);

  p_pf_lat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_grant_o |=> pf_rvalid_o);
endmodule

// File: tb/sim_mem_space_router.sv
`timescale 1ns/1ps
module sim_mem_space_router;
  localparam logic [1:0] S_CODE = 2'd0, S_DATA = 2'd1, S_SFR = 2'd2, S_XD = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cpu_req = 0, cpu_ind = 0, cpu_bit = 0, cpu_we = 0;
  logic [1:0] cpu_sp = 0;
  logic [15:0] cpu_addr = 0;
  logic [2:0] cpu_bs = 0;
  logic [7:0] cpu_wd = 0;
  logic dma_req = 0, dma_we = 0;
  logic [15:0] dma_addr = 0;
  logic [7:0] dma_wd = 0;
  logic pf_req = 0;
  logic [15:0] pf_addr = 0;
  logic cpu_rvalid, dma_ready, dma_rvalid, pf_grant, pf_rvalid, err;
  logic [7:0] cpu_rdata, dma_rdata, pf_rdata;
  logic flash_en, sram_en, sram_we, sfr_en, sfr_we;
  logic [15:0] flash_addr;
  logic [7:0] sram_addr, sram_wd, sfr_addr, sfr_mask, sfr_wd;
  logic [7:0] flash_rd = 0, sram_rd = 0, sfr_rd = 0;
  logic [7:0] sram_m [256];
  logic [7:0] sfr_m [256];

  int n_tests = 0, n_fail = 0;

  typedef struct {
    bit dma; bit rd; logic [7:0] d; bit e; string tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  mem_space_router u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_space_i(cpu_sp), .cpu_addr_i(cpu_addr),
    .cpu_indirect_i(cpu_ind), .cpu_bit_i(cpu_bit), .cpu_bitsel_i(cpu_bs),
    .cpu_we_i(cpu_we), .cpu_wdata_i(cpu_wd),
    .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
    .dma_req_i(dma_req), .dma_addr_i(dma_addr), .dma_we_i(dma_we), .dma_wdata_i(dma_wd),
    .dma_ready_o(dma_ready), .dma_rvalid_o(dma_rvalid), .dma_rdata_o(dma_rdata),
    .pf_req_i(pf_req), .pf_addr_i(pf_addr), .pf_grant_o(pf_grant),
    .pf_rvalid_o(pf_rvalid), .pf_rdata_o(pf_rdata), .err_o(err),
    .flash_en_o(flash_en), .flash_addr_o(flash_addr), .flash_rdata_i(flash_rd),
    .sram_en_o(sram_en), .sram_we_o(sram_we), .sram_addr_o(sram_addr),
    .sram_wdata_o(sram_wd), .sram_rdata_i(sram_rd),
    .sfr_en_o(sfr_en), .sfr_we_o(sfr_we), .sfr_addr_o(sfr_addr),
    .sfr_wmask_o(sfr_mask), .sfr_wdata_o(sfr_wd), .sfr_rdata_i(sfr_rd)
  );

  function automatic logic [7:0] fl(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // one-cycle synchronous memory models
  always @(posedge clk) begin
    if (flash_en) flash_rd <= fl(flash_addr);
    if (sram_en) begin
      if (sram_we) sram_m[sram_addr] <= sram_wd;
      else sram_rd <= sram_m[sram_addr];
    end
    if (sfr_en) begin
      if (sfr_we) sfr_m[sfr_addr] <= (sfr_m[sfr_addr] & ~sfr_mask) | (sfr_wd & sfr_mask);
      else sfr_rd <= sfr_m[sfr_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit is_dma, input logic [1:0] sp, input logic [15:0] a,
                     input bit ind, input bit bt, input logic [2:0] bs, input bit we,
                     input logic [7:0] wd, input logic [7:0] exp, input bit experr, input string tag);
    item_t it;
    @(negedge clk);
    cpu_req = !is_dma; dma_req = is_dma;
    cpu_sp = sp; cpu_addr = a; cpu_ind = ind; cpu_bit = bt; cpu_bs = bs; cpu_we = we; cpu_wd = wd;
    dma_addr = a; dma_we = we; dma_wd = wd;
    it.dma = is_dma; it.rd = !we; it.d = exp; it.e = experr; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_req = 0; dma_req = 0; cpu_bit = 0; cpu_ind = 0; cpu_we = 0; dma_we = 0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        logic rv;
        logic [7:0] rd;
        it = q.pop_front();
        rv = it.dma ? dma_rvalid : cpu_rvalid;
        rd = it.dma ? dma_rdata : cpu_rdata;
        chk(rv == it.rd, {it.tag, " R12 valid"}, 16'(rv), 16'(it.rd));
        if (it.rd) chk(rd == it.d, {it.tag, " data"}, 16'(rd), 16'(it.d));
        chk(err == it.e, {it.tag, " R11 err"}, 16'(err), 16'(it.e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin sram_m[i] = 8'h00; sfr_m[i] = 8'h00; end
    pf_req = 1; pf_addr = 16'h0100;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk(!cpu_rvalid && !dma_rvalid && !err, "reset outputs", 16'(cpu_rvalid), 0);
    chk(!pf_grant, "R9 reset prefetch off", 16'(pf_grant), 0);
    pf_req = 0;

    // R2
    acc(0, S_DATA, 16'h0010, 0, 0, 0, 1, 8'h3C, 0, 0, "R2 wr lo direct");
    acc(0, S_DATA, 16'h0010, 1, 0, 0, 0, 0, 8'h3C, 0, "R2 rd lo indirect");
    acc(0, S_DATA, 16'h0090, 1, 0, 0, 1, 8'hA5, 0, 0, "R2 wr hi indirect");
    acc(0, S_DATA, 16'h0090, 1, 0, 0, 0, 0, 8'hA5, 0, "R2 rd hi indirect");
    // R3
    acc(0, S_DATA, 16'h0090, 0, 0, 0, 1, 8'h77, 0, 0, "R3 wr hi direct");
    acc(0, S_SFR,  16'h0090, 0, 0, 0, 0, 0, 8'h77, 0, "R3 rd sfr");
    acc(0, S_DATA, 16'h0090, 1, 0, 0, 0, 0, 8'hA5, 0, "R3 sram untouched");
    acc(0, S_SFR,  16'h0090, 1, 0, 0, 0, 0, 8'h00, 1, "R3 sfr indirect rejected");
    acc(0, S_SFR,  16'h0010, 0, 0, 0, 0, 0, 8'h00, 1, "R3 sfr low rejected");
    // R5
    acc(1, S_XD, 16'hFF10, 0, 0, 0, 0, 0, 8'h3C, 0, "R5 dma sram alias");
    acc(1, S_XD, 16'h7090, 0, 0, 0, 0, 0, 8'h77, 0, "R5 dma sfr alias");
    acc(1, S_XD, 16'hFF20, 0, 0, 0, 1, 8'h11, 0, 0, "R5 dma wr sram alias");
    acc(0, S_DATA, 16'h0020, 0, 0, 0, 0, 0, 8'h11, 0, "R5 cpu sees dma write");
    // R4
    acc(0, S_SFR, 16'h0088, 0, 0, 0, 1, 8'h00, 0, 0, "R4 clear");
    acc(0, S_SFR, 16'h0088, 0, 1, 3, 1, 8'h01, 0, 0, "R4 bit set");
    acc(0, S_SFR, 16'h0088, 0, 0, 0, 0, 0, 8'h08, 0, "R4 byte after bit");
    acc(0, S_SFR, 16'h0088, 0, 1, 3, 0, 0, 8'h01, 0, "R4 bit rd set");
    acc(0, S_SFR, 16'h0088, 0, 1, 2, 0, 0, 8'h00, 0, "R4 bit rd clear");
    acc(0, S_SFR, 16'h0089, 0, 0, 0, 1, 8'h55, 0, 0, "R4 wr 89");
    acc(0, S_SFR, 16'h0089, 0, 1, 0, 1, 8'h00, 0, 1, "R4 bit unaligned rejected");
    acc(0, S_SFR, 16'h0089, 0, 0, 0, 0, 0, 8'h55, 0, "R4 unaligned no effect");
    acc(0, S_DATA, 16'h0010, 0, 1, 0, 0, 0, 8'h00, 1, "R4 bit on sram rejected");
    // R6, R1, R10 default, R11
    acc(0, S_XD,   16'h1234, 0, 0, 0, 0, 0, fl(16'h1234), 0, "R6 flash rd");
    acc(0, S_XD,   16'h1234, 0, 0, 0, 1, 8'h99, 0, 1, "R6 flash wr rejected");
    acc(0, S_CODE, 16'h4000, 0, 0, 0, 0, 0, fl(16'h4000), 0, "R1 code rd");
    acc(0, S_CODE, 16'h4000, 0, 0, 0, 1, 8'h99, 0, 1, "R1 code wr rejected");
    acc(0, S_CODE, 16'hFF10, 0, 0, 0, 0, 0, fl(16'hFF10), 0, "R10 default map flash");
    acc(0, S_XD,   16'h8000, 0, 0, 0, 0, 0, 8'h00, 1, "R11 unmapped rd");
    acc(1, S_XD,   16'h8000, 0, 0, 0, 1, 8'h42, 0, 1, "R11 unmapped wr");
    acc(0, S_XD,   16'h7100, 0, 0, 0, 0, 0, 8'h00, 1, "R11 gap rd");
    // R9 enable prefetch
    acc(0, S_SFR, 16'h00C8, 0, 0, 0, 1, 8'h01, 0, 0, "R9 ctrl wr");
    acc(0, S_SFR, 16'h00C8, 0, 0, 0, 0, 0, 8'h01, 0, "R9 ctrl rd");
    idle();
    pf_req = 1; pf_addr = 16'h0100;
    #1 chk(pf_grant, "R9 prefetch granted", 16'(pf_grant), 1);
    @(posedge clk); #2;
    chk(pf_rvalid && pf_rdata == fl(16'h0100), "R12 prefetch data", 16'(pf_rdata), 16'(fl(16'h0100)));
    // R8
    acc(0, S_XD, 16'h0200, 0, 0, 0, 0, 0, fl(16'h0200), 0, "R8 xdata rd");
    #1 chk(!pf_grant, "R8 held by cpu xdata", 16'(pf_grant), 0);
    acc(0, S_CODE, 16'h0300, 0, 0, 0, 0, 0, fl(16'h0300), 0, "R8 code rd");
    #1 chk(!pf_grant, "R8 held by cpu code", 16'(pf_grant), 0);
    acc(1, S_XD, 16'h0400, 0, 0, 0, 0, 0, fl(16'h0400), 0, "R8 dma rd");
    #1 chk(!pf_grant, "R8 held by dma", 16'(pf_grant), 0);
    acc(0, S_DATA, 16'h0010, 0, 0, 0, 0, 0, 8'h3C, 0, "R8 data rd");
    #1 chk(pf_grant, "R8 allowed with data", 16'(pf_grant), 1);
    idle();
    pf_req = 0;
    // R7
    @(negedge clk);
    begin
      item_t it;
      cpu_req = 1; cpu_sp = S_DATA; cpu_addr = 16'h0010; cpu_we = 0; cpu_bit = 0; cpu_ind = 0;
      dma_req = 1; dma_addr = 16'hFF20; dma_we = 0;
      it.dma = 0; it.rd = 1; it.d = 8'h3C; it.e = 0; it.tag = "R7 cpu wins";
      q.push_back(it);
      #1 chk(!dma_ready, "R7 dma stalled", 16'(dma_ready), 0);
      @(negedge clk);
      cpu_req = 0;
      it.dma = 1; it.rd = 1; it.d = 8'h11; it.e = 0; it.tag = "R7 dma served";
      q.push_back(it);
      #1 chk(dma_ready, "R7 dma granted", 16'(dma_ready), 1);
    end
    // R10 alternate map, prefetch off
    acc(0, S_SFR, 16'h00C8, 0, 0, 0, 1, 8'h02, 0, 0, "R10 ctrl alt");
    acc(0, S_CODE, 16'hFF10, 0, 0, 0, 0, 0, 8'h3C, 0, "R10 alt code sram");
    acc(0, S_CODE, 16'h0010, 0, 0, 0, 0, 0, fl(16'h0010), 0, "R10 alt code low flash");
    idle();
    pf_req = 1;
    #1 chk(!pf_grant, "R9 prefetch disabled", 16'(pf_grant), 0);
    pf_req = 0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "scoreboard drained", 16'(q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule